// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This unit carries out the one-operand arithmetic and logic group of a 16-bit minicomputer-style processor. Each request supplies the upper ten bits of the instruction word, the fetched operand and the current four condition codes. One clock later the unit returns the value to write back, the updated condition codes and a write-enable that the surrounding datapath uses to decide whether the destination is stored. Operand addressing and memory traffic belong to the caller.

The operation can work on the full word or only on the low byte. In byte form the sign is taken from bit 7 and the upper byte of the operand passes through untouched. The rotates pass through the carry flag, and add-carry and subtract-carry let software chain words into longer integers. Any pattern that is not one of the supported functions is returned as a no-op that leaves the flags alone and asks for no write.

Top module: `sop_alu`

## Requirements
- R1: Outputs are registered: `result`, `flags_out` and `wr_en` for a request accepted with `in_valid` high appear on the next rising clock edge, together with `out_valid`; `out_valid` and `wr_en` are low in any cycle after an edge with `in_valid` low, and reset clears every output to zero.
- R2: `op_hi` holds instruction bits 15:6; `op_hi[9]` selects byte mode, `op_hi[8:6]` must be 000 and `op_hi[5:0]` picks the function (octal 50 clear, 51 complement, 52 increment, 53 decrement, 54 negate, 55 add carry, 56 subtract carry, 57 test, 60 rotate right, 61 rotate left, 62 shift right, 63 shift left, 67 sign extend). Flags are packed as N=bit 3, Z=bit 2, V=bit 1, C=bit 0. Any other pattern gives `wr_en`=0, `result`=operand and `flags_out`=`flags_in`.
- R3: In byte mode the function acts on bits 7:0 with bit 7 as sign, N and Z come from the low byte, and `result[15:8]` equals `operand[15:8]`.
- R4: Clear gives 0 with flags 0100; complement inverts every bit with V=0, C=1; test returns the operand unchanged with V=0, C=0 and `wr_en`=0. For these and all arithmetic and shift functions N is the result sign and Z is set when the result is zero.
- R5: Increment and decrement add or subtract one modulo the width, set V when the result crosses the signed limit (largest positive to most negative or back), and keep C unchanged.
- R6: Negate returns the two's complement, sets V only when the result is the most negative value, and sets C whenever the result is nonzero.
- R7: Add carry adds C and subtract carry subtracts C; V is set when the result crosses the signed limit; C is set for add carry when the operand is all ones and C was 1, and for subtract carry when the operand is zero and C was 1.
- R8: Rotate right puts old C into the sign bit and bit 0 into C; rotate left puts old C into bit 0 and the sign bit into C; V becomes N XOR C.
- R9: Arithmetic shift right keeps the sign bit and moves bit 0 into C; shift left inserts 0 at bit 0 and moves the sign bit into C; V becomes N XOR C.
- R10: Sign extend (word only) writes all ones when N is set and all zeros otherwise, keeps N and C, sets Z to NOT N and clears V; the byte form of code 67 is an unused pattern.
- R11: `op_hi` = 0000000011 swaps the two bytes, sets N and Z from the low byte of the result and clears V and C; the same pattern with `op_hi[9]`=1 is an unused pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_hi | input | 10 | Instruction bits 15:6 |
| operand | input | 16 | Operand value |
| flags_in | input | 4 | Current N, Z, V, C |
| out_valid | output | 1 | Result registers hold a fresh answer |
| result | output | 16 | Value to write back |
| flags_out | output | 4 | New N, Z, V, C |
| wr_en | output | 1 | Destination should be written |

## Verification
The rarest situations are the single-value flag boundaries: overflow on increment only from the largest positive value, carry-out of add carry only from all ones with C set, negate of the most negative value, and the byte-wide versions of each with an unrelated upper byte. Uniform random operands almost never hit them, so the bench drives them directly and also biases the random operand toward the extreme values of both widths. Random instruction patterns with nonzero group bits, the byte-mode swap pattern and byte sign extend exercise the unused-code path.

// File: rtl/sop_pkg.sv
package sop_pkg;

   typedef enum logic [3:0] {
      K_CLR, K_COM, K_INC, K_DEC, K_NEG, K_ADC, K_SBC, K_TST,
      K_ROR, K_ROL, K_ASR, K_ASL, K_SXT, K_SWAB, K_NONE
   } sop_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccode_t;

   localparam int OPHI_W = 10;

endpackage

// File: rtl/sop_decode.sv
module sop_decode
   import sop_pkg::*;
#(
   parameter bit BYTE_OPS = 1'b1
) (
   input  logic [OPHI_W-1:0] op_hi,
   output sop_kind_e         kind,
   output logic              is_byte
);

   localparam logic [OPHI_W-1:0] SWAP_PAT = 10'b0000000011;

   logic [5:0] fn;
   logic       grp_ok;

   assign fn      = op_hi[5:0];
   assign grp_ok  = (op_hi[8:6] == 3'b000);
   assign is_byte = op_hi[9];

   always_comb begin
      kind = K_NONE;
      if (op_hi == SWAP_PAT) begin
         kind = K_SWAB;
      end else if (grp_ok && !(is_byte && !BYTE_OPS)) begin
         case (fn)
            6'o50:   kind = K_CLR;
            6'o51:   kind = K_COM;
            6'o52:   kind = K_INC;
            6'o53:   kind = K_DEC;
            6'o54:   kind = K_NEG;
            6'o55:   kind = K_ADC;
            6'o56:   kind = K_SBC;
            6'o57:   kind = K_TST;
            6'o60:   kind = K_ROR;
            6'o61:   kind = K_ROL;
            6'o62:   kind = K_ASR;
            6'o63:   kind = K_ASL;
            6'o67:   kind = is_byte ? K_NONE : K_SXT;
            default: kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sop_core.sv
module sop_core
   import sop_pkg::*;
#(
   parameter int W = 16
) (
   input  sop_kind_e    kind,
   input  logic [W-1:0] x,
   input  ccode_t       cin,
   output logic [W-1:0] r,
   output ccode_t       cout,
   output logic         wr
);

   localparam int MSB = W - 1;

   logic [W:0]   add_ext;
   logic [W-1:0] sub_c;

   assign add_ext = {1'b0, x} + {{W{1'b0}}, cin.c};
   assign sub_c   = x - {{(W-1){1'b0}}, cin.c};

   always_comb begin
      r    = x;
      cout = cin;
      wr   = 1'b1;
      case (kind)
         K_CLR: begin
            r      = '0;
            cout.v = 1'b0;
            cout.c = 1'b0;
         end
         K_COM: begin
            r      = ~x;
            cout.v = 1'b0;
            cout.c = 1'b1;
         end
         K_INC: begin
            r      = x + 1'b1;
            cout.v = ~x[MSB] & r[MSB];
         end
         K_DEC: begin
            r      = x - 1'b1;
            cout.v = x[MSB] & ~r[MSB];
         end
         K_NEG: begin
            r      = ~x + 1'b1;
            cout.v = x[MSB] & r[MSB];
            cout.c = |r;
         end
         K_ADC: begin
            r      = add_ext[W-1:0];
            cout.v = ~x[MSB] & r[MSB];
            cout.c = add_ext[W];
         end
         K_SBC: begin
            r      = sub_c;
            cout.v = x[MSB] & ~r[MSB];
            cout.c = cin.c & ~(|x);
         end
         K_TST: begin
            wr     = 1'b0;
            cout.v = 1'b0;
            cout.c = 1'b0;
         end
         K_ROR: begin
            r      = {cin.c, x[MSB:1]};
            cout.c = x[0];
         end
         K_ROL: begin
            r      = {x[MSB-1:0], cin.c};
            cout.c = x[MSB];
         end
         K_ASR: begin
            r      = {x[MSB], x[MSB:1]};
            cout.c = x[0];
         end
         K_ASL: begin
            r      = {x[MSB-1:0], 1'b0};
            cout.c = x[MSB];
         end
         K_SXT: begin
            r      = {W{cin.n}};
            cout.v = 1'b0;
         end
         default: begin
            wr = 1'b0;
         end
      endcase

      if (kind != K_NONE && kind != K_SXT && kind != K_SWAB) begin
         cout.n = r[MSB];
         cout.z = ~(|r);
      end
      if (kind == K_SXT) begin
         cout.z = ~cin.n;
      end
      if (kind inside {K_ROR, K_ROL, K_ASR, K_ASL}) begin
         cout.v = cout.n ^ cout.c;
      end
   end

endmodule

// File: rtl/sop_alu.sv
module sop_alu
   import sop_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter bit BYTE_OPS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [OPHI_W-1:0]    op_hi,
   input  logic [WIDTH-1:0]     operand,
   input  logic [3:0]           flags_in,
   output logic                 out_valid,
   output logic [WIDTH-1:0]     result,
   output logic [3:0]           flags_out,
   output logic                 wr_en
);

   localparam int HALF = WIDTH / 2;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("sop_alu: WIDTH must be even and at least 4");
      end
   endgenerate

   sop_kind_e kind;
   logic      is_byte;
   ccode_t    cc_in;

   assign cc_in = ccode_t'(flags_in);

   sop_decode #(.BYTE_OPS(BYTE_OPS)) u_dec (
      .op_hi   (op_hi),
      .kind    (kind),
      .is_byte (is_byte)
   );

   logic [WIDTH-1:0] w_res;
   ccode_t           w_cc;
   logic             w_wr;

   sop_core #(.W(WIDTH)) u_word (
      .kind (kind),
      .x    (operand),
      .cin  (cc_in),
      .r    (w_res),
      .cout (w_cc),
      .wr   (w_wr)
   );

   logic [HALF-1:0] b_res;
   ccode_t          b_cc;
   logic            b_wr;

   generate
      if (BYTE_OPS) begin : g_byte_lane
         sop_core #(.W(HALF)) u_byte (
            .kind (kind),
            .x    (operand[HALF-1:0]),
            .cin  (cc_in),
            .r    (b_res),
            .cout (b_cc),
            .wr   (b_wr)
         );
      end else begin : g_no_byte_lane
         assign b_res = operand[HALF-1:0];
         assign b_cc  = cc_in;
         assign b_wr  = 1'b0;
      end
   endgenerate

   logic [WIDTH-1:0] swap_res;
   ccode_t           swap_cc;

   assign swap_res   = {operand[HALF-1:0], operand[WIDTH-1:HALF]};
   assign swap_cc.n  = swap_res[HALF-1];
   assign swap_cc.z  = ~(|swap_res[HALF-1:0]);
   assign swap_cc.v  = 1'b0;
   assign swap_cc.c  = 1'b0;

   logic [WIDTH-1:0] nxt_res;
   ccode_t           nxt_cc;
   logic             nxt_wr;

   always_comb begin
      if (kind == K_SWAB) begin
         nxt_res = swap_res;
         nxt_cc  = swap_cc;
         nxt_wr  = 1'b1;
      end else if (is_byte) begin
         nxt_res = {operand[WIDTH-1:HALF], b_res};
         nxt_cc  = b_cc;
         nxt_wr  = b_wr;
      end else begin
         nxt_res = w_res;
         nxt_cc  = w_cc;
         nxt_wr  = w_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flags_out <= '0;
         wr_en     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid & nxt_wr;
         if (in_valid) begin
            result    <= nxt_res;
            flags_out <= nxt_cc;
         end
      end
   end

endmodule

// File: rtl/sop_alu_chk.sv
module sop_alu_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [9:0]       op_hi,
   input logic [WIDTH-1:0] operand,
   input logic [3:0]       flags_in,
   input logic             out_valid,
   input logic [WIDTH-1:0] result,
   input logic [3:0]       flags_out,
   input logic             wr_en
);

   localparam int HALF = WIDTH / 2;

   logic byte_arith;
   logic bad_grp;
   assign byte_arith = op_hi[9] && (op_hi[8:6] == 3'b000) &&
                       (op_hi[5:0] >= 6'o50) && (op_hi[5:0] <= 6'o63);
   assign bad_grp    = (op_hi[8:6] != 3'b000);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!out_valid && !wr_en);
      end
   end

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wr_en));

   assert_unused_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bad_grp) |=>
         (!wr_en && flags_out == $past(flags_in) && result == $past(operand)));

   assert_byte_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && byte_arith) |=> (result[WIDTH-1:HALF] == $past(operand[WIDTH-1:HALF])));

   assert_clear_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_hi == 10'o0050) |=> (result == '0 && flags_out == 4'b0100 && wr_en));

   assert_test_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_hi[8:0] == 9'o057) |=> (!wr_en && result == $past(operand)));

   assert_sxt_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_hi == 10'o0067) |=>
         (flags_out[3] == $past(flags_in[3]) && flags_out[0] == $past(flags_in[0]) &&
          flags_out[2] == !$past(flags_in[3]) && !flags_out[1]));

   assert_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_hi == 10'b0000000011) |=>
         (result == {$past(operand[HALF-1:0]), $past(operand[WIDTH-1:HALF])} && wr_en));

endmodule

bind sop_alu sop_alu_chk #(.WIDTH(WIDTH)) u_sop_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_hi     (op_hi),
   .operand   (operand),
   .flags_in  (flags_in),
   .out_valid (out_valid),
   .result    (result),
   .flags_out (flags_out),
   .wr_en     (wr_en)
);

// File: tb/sop_alu_test.sv
module sop_alu_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [9:0]  op_hi = '0;
   logic [15:0] operand = '0;
   logic [3:0]  flags_in = '0;
   logic        out_valid;
   logic [15:0] result;
   logic [3:0]  flags_out;
   logic        wr_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sop_alu uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_hi(op_hi),
      .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
      .result(result), .flags_out(flags_out), .wr_en(wr_en)
   );

   // returns {wr, result[15:0], flags[3:0]}
   function automatic logic [20:0] ref_op(logic [9:0] oh, logic [15:0] x, logic [3:0] f);
      logic [15:0] mask, sb, v, r;
      logic n, z, vv, c, wr, cin, nin;
      logic [5:0] fn;
      fn = oh[5:0];
      mask = oh[9] ? 16'h00FF : 16'hFFFF;
      sb   = oh[9] ? 16'h0080 : 16'h8000;
      v = x & mask;
      cin = f[0]; nin = f[3];
      n = f[3]; z = f[2]; vv = f[1]; c = f[0]; wr = 1'b1; r = v;
      if (oh == 10'b0000000011) begin
         r = {x[7:0], x[15:8]};
         return {1'b1, r, r[7], (r[7:0] == 8'h00), 2'b00};
      end
      if (oh[8:6] != 3'b000 || (oh[9] && fn == 6'o67)) return {1'b0, x, f};
      case (fn)
         6'o50: begin r = 0; vv = 0; c = 0; end
         6'o51: begin r = ~v & mask; vv = 0; c = 1; end
         6'o52: begin r = (v + 16'd1) & mask; vv = (v == sb - 16'd1); end
         6'o53: begin r = (v - 16'd1) & mask; vv = (v == sb); end
         6'o54: begin r = (16'd0 - v) & mask; vv = (r == sb); c = (r != 0); end
         6'o55: begin r = (v + {15'd0, cin}) & mask; vv = cin && v == sb - 16'd1; c = cin && v == mask; end
         6'o56: begin r = (v - {15'd0, cin}) & mask; vv = cin && v == sb; c = cin && v == 0; end
         6'o57: begin wr = 0; vv = 0; c = 0; end
         6'o60: begin r = (v >> 1) | (cin ? sb : 16'd0); c = v[0]; end
         6'o61: begin r = ((v << 1) & mask) | {15'd0, cin}; c = (v & sb) != 0; end
         6'o62: begin r = (v >> 1) | (v & sb); c = v[0]; end
         6'o63: begin r = (v << 1) & mask; c = (v & sb) != 0; end
         6'o67: return {1'b1, (nin ? 16'hFFFF : 16'h0000), nin, !nin, 1'b0, cin};
         default: return {1'b0, x, f};
      endcase
      n = (r & sb) != 0;
      z = (r == 0);
      if (fn >= 6'o60) vv = n ^ c;
      return {wr, (x & ~mask) | r, n, z, vv, c};
   endfunction

   function automatic string tag_of(logic [9:0] oh);
      if (oh[5:0] == 6'o03 && oh[8:6] == 3'b000 && !oh[9]) return "R11";
      if (oh[8:6] != 3'b000) return "R2";
      if (oh[5:0] == 6'o03) return "R11";
      if (oh[5:0] == 6'o67) return oh[9] ? "R10/R2" : "R10";
      if (oh[9] && oh[5:0] >= 6'o50 && oh[5:0] <= 6'o63) return "R3";
      case (oh[5:0])
         6'o50, 6'o51, 6'o57: return "R4";
         6'o52, 6'o53:        return "R5";
         6'o54:               return "R6";
         6'o55, 6'o56:        return "R7";
         6'o60, 6'o61:        return "R8";
         6'o62, 6'o63:        return "R9";
         default:             return "R2";
      endcase
   endfunction

   task automatic run_op(logic [9:0] oh, logic [15:0] x, logic [3:0] f);
      logic [20:0] exp;
      exp = ref_op(oh, x, f);
      @(negedge clk);
      in_valid = 1'b1; op_hi = oh; operand = x; flags_in = f;
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (!out_valid || wr_en !== exp[20] || result !== exp[19:4] || flags_out !== exp[3:0]) begin
         failures++;
         $display("FAIL %s op=%o x=%h f=%b : got v=%b wr=%b res=%h fl=%b exp v=1 wr=%b res=%h fl=%b",
                  tag_of(oh), oh, x, f, out_valid, wr_en, result, flags_out,
                  exp[20], exp[19:4], exp[3:0]);
      end
   endtask

   function automatic logic [15:0] pick_val();
      case ($urandom % 8)
         0: return 16'h7FFF;
         1: return 16'h8000;
         2: return 16'hFFFF;
         3: return 16'h0000;
         4: return {8'($urandom), 8'h7F};
         5: return {8'($urandom), 8'h80};
         6: return {8'($urandom), 8'hFF};
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      logic [5:0] codes [13] = '{6'o50, 6'o51, 6'o52, 6'o53, 6'o54, 6'o55, 6'o56,
                                 6'o57, 6'o60, 6'o61, 6'o62, 6'o63, 6'o67};
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid || wr_en || result !== 16'h0 || flags_out !== 4'h0) begin
         failures++;
         $display("FAIL R1 reset: got v=%b wr=%b res=%h fl=%b exp all zero",
                  out_valid, wr_en, result, flags_out);
      end
      rst_n = 1'b1;

      // directed corners
      run_op(10'o0052, 16'h7FFF, 4'b0001);  // R5 overflow, C kept
      run_op(10'o0053, 16'h8000, 4'b0000);  // R5
      run_op(10'o1052, 16'hAB7F, 4'b0000);  // R3 byte inc overflow
      run_op(10'o0054, 16'h8000, 4'b0000);  // R6
      run_op(10'o0054, 16'h0000, 4'b1111);  // R6
      run_op(10'o0055, 16'hFFFF, 4'b0001);  // R7
      run_op(10'o0056, 16'h0000, 4'b0001);  // R7
      run_op(10'o1055, 16'h12FF, 4'b0001);  // R3/R7 byte carry
      run_op(10'o0060, 16'h0001, 4'b0001);  // R8
      run_op(10'o1061, 16'hCD80, 4'b0000);  // R8 byte
      run_op(10'o0062, 16'h8001, 4'b0000);  // R9
      run_op(10'o0063, 16'h4000, 4'b0000);  // R9
      run_op(10'o0067, 16'h1234, 4'b1001);  // R10
      run_op(10'o0067, 16'h1234, 4'b0110);  // R10
      run_op(10'o1067, 16'h1234, 4'b1010);  // R10 byte form unused
      run_op(10'o0003, 16'h80FF, 4'b1111);  // R11
      run_op(10'o1003, 16'h1234, 4'b0101);  // R11 byte pattern unused
      run_op(10'o0064, 16'h5555, 4'b1010);  // R2 unused code
      run_op(10'o0057, 16'h8000, 4'b0111);  // R4 test
      run_op(10'o0050, 16'hFFFF, 4'b1011);  // R4 clear
      run_op(10'o0051, 16'h0F0F, 4'b0000);  // R4 complement

      // R1: idle cycle drops out_valid and wr_en
      @(negedge clk);
      checks++;
      if (out_valid || wr_en) begin
         failures++;
         $display("FAIL R1 idle: got v=%b wr=%b exp v=0 wr=0", out_valid, wr_en);
      end

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [9:0] oh;
         int k;
         k = $urandom % 20;
         oh[9]   = 1'($urandom);
         oh[8:6] = (($urandom % 16) == 0) ? 3'($urandom) : 3'b000;
         oh[5:0] = (k < 13) ? codes[k] : ((k == 13) ? 6'o03 : 6'($urandom));
         run_op(oh, pick_val(), 4'($urandom));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule